// File: doc/BRIEF.md
# ATA Task-File Register Block

This block holds the host-visible task-file registers of one ATA device that shares a channel with a second device. The host reaches it over a byte-wide register bus with a 3-bit offset and a select line that picks either the command block or the control block. At several offsets a read and a write reach different registers. Status and command share one offset. Error and features share another. In the control block, alternate status and device control share one.

The block holds the features, sector count, sector number, cylinder and drive/head registers. It presents the 28-bit logical block address that those registers form and compares the device-select bit with a strapped device number. A command write starts a one-cycle start pulse for the execution engine, which lies outside this block. When the engine reports completion, the block updates status and raises a pending interrupt. The device-control register masks that interrupt and provides a soft reset. The 16-bit data port and command execution are not part of this block.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After `rst_n` is released, status reads 0x40, the task-file registers read zero, and `intrq`, `cmd_start` and `soft_rst` are low. Status bit positions: BSY bit 7, DRDY bit 6, DRQ bit 3, ERR bit 0.
- R2: In the command block (`bus_ctl`=0), reads at offsets 1 through 6 return the error, sector count, sector number, cylinder low, cylinder high and drive/head registers. Writes at offsets 2 through 6 load those same registers. Offset 0 reads zero and ignores writes.
- R3: Command-block offset 7 reads status and takes the command on a write. Offset 1 takes features on a write, and features is never returned on a read. Control-block offset 2 reads alternate status, which is the same byte as status, and takes device control on a write. All other control-block offsets read zero.
- R4: The device is selected when drive/head bit 4 equals `DEV_ID`. While it is not selected, reads return zero, command writes are ignored and `intrq` is low. Task-file writes are still accepted.
- R5: `lba` equals {drive/head[3:0], cylinder high, cylinder low, sector number}, and `lba_mode` equals drive/head bit 6.
- R6: A command write made while the device is selected and not busy latches `cmd_code`. It pulses `cmd_start` for exactly the following cycle, sets BSY, clears DRDY and ERR, and drops any pending interrupt.
- R7: `exec_done` while busy leaves status at exactly 0x40, or 0x41 when `exec_err` is high. With an error, the error register takes `err_code`; otherwise it becomes zero. In both cases an interrupt becomes pending.
- R8: `intrq` is high when an interrupt is pending, the device is selected and device-control bit 1 (nIEN) is clear. A read of status clears the pending interrupt. A read of alternate status leaves it pending.
- R9: While BSY is set, command-block writes are ignored and device-control writes still take effect.
- R10: A device-control write with bit 2 set raises `soft_rst` and BSY, clears the task-file and error registers, and drops any pending interrupt. A later device-control write with bit 2 clear lowers `soft_rst`. BSY then stays set for `RST_HOLD` more cycles, after which status reads 0x40.
- R11: The DRQ status bit follows `drq_i` while BSY is clear and reads zero while BSY is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access strobe |
| bus_ctl | input | 1 | 0 = command block, 1 = control block |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| exec_done | input | 1 | Command completion from execution engine |
| exec_err | input | 1 | Completion ended in error |
| err_code | input | 8 | Error register value on error completion |
| drq_i | input | 1 | Data request from data engine |
| dev_sel | output | 1 | Device is selected |
| lba | output | 28 | Assembled logical block address |
| lba_mode | output | 1 | LBA addressing mode flag |
| sector_count | output | 8 | Sector count register |
| features | output | 8 | Features register |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_code | output | 8 | Latched command code |
| soft_rst | output | 1 | Soft reset held by device control |
| intrq | output | 1 | Interrupt request to host |

## Verification
The bench builds the block with `DEV_ID`=0 and `RST_HOLD`=3. Because the device-select bit resets to zero, status and registers can be read back right after a soft reset. The short hold lets the bench count each cycle of the post-reset busy window. With `DEV_ID`=0, writing drive/head bit 4 as one deselects the device. This exercises the gating of reads, commands and the interrupt request for the unselected device. A behavioural model predicts read data, interrupt, start pulse and address on every clock while commands, completions, masking and reset sequences are driven.

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter logic DEV_ID   = 1'b0,
  parameter int   RST_HOLD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_ctl,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        exec_done,
  input  logic        exec_err,
  input  logic [7:0]  err_code,
  input  logic        drq_i,
  output logic        dev_sel,
  output logic [27:0] lba,
  output logic        lba_mode,
  output logic [7:0]  sector_count,
  output logic [7:0]  features,
  output logic        cmd_start,
  output logic [7:0]  cmd_code,
  output logic        soft_rst,
  output logic        intrq
);

  localparam int HW = $clog2(RST_HOLD + 1);

  logic [7:0]    feat_q, secc_q, secn_q, cyll_q, cylh_q, dh_q, err_q, cmd_q;
  logic          bsy, drdy, errb, pend, nien, srst, start_q;
  logic [HW-1:0] hold_cnt;
  logic [7:0]    status;

  wire wr_acc  = bus_cs & bus_wr;
  wire rd_acc  = bus_cs & bus_rd;
  wire cb_wr   = wr_acc & ~bus_ctl;
  wire ctl_wr  = wr_acc & bus_ctl & (bus_addr == 3'd2);
  wire tf_ok   = cb_wr & ~bsy;
  wire cmd_wr  = tf_ok & (bus_addr == 3'd7) & dev_sel;
  wire stat_rd = rd_acc & ~bus_ctl & (bus_addr == 3'd7) & dev_sel;
  wire done_ok = exec_done & bsy & ~srst & (hold_cnt == '0);

  assign dev_sel      = (dh_q[4] == DEV_ID);
  assign status       = {bsy, drdy, 2'b00, drq_i & ~bsy, 2'b00, errb};
  assign lba          = {dh_q[3:0], cylh_q, cyll_q, secn_q};
  assign lba_mode     = dh_q[6];
  assign sector_count = secc_q;
  assign features     = feat_q;
  assign cmd_start    = start_q;
  assign cmd_code     = cmd_q;
  assign soft_rst     = srst;
  assign intrq        = pend & ~nien & dev_sel;

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_acc && dev_sel) begin
      if (bus_ctl) begin
        if (bus_addr == 3'd2) bus_rdata = status;
      end else begin
        case (bus_addr)
          3'd1: bus_rdata = err_q;
          3'd2: bus_rdata = secc_q;
          3'd3: bus_rdata = secn_q;
          3'd4: bus_rdata = cyll_q;
          3'd5: bus_rdata = cylh_q;
          3'd6: bus_rdata = dh_q;
          3'd7: bus_rdata = status;
          default: bus_rdata = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0; secc_q <= '0; secn_q <= '0; cyll_q <= '0;
      cylh_q <= '0; dh_q <= '0; err_q <= '0; cmd_q <= '0;
      bsy <= 1'b0; drdy <= 1'b1; errb <= 1'b0; pend <= 1'b0;
      nien <= 1'b0; srst <= 1'b0; start_q <= 1'b0; hold_cnt <= '0;
    end else begin
      start_q <= cmd_wr;
      if (tf_ok) begin
        case (bus_addr)
          3'd1: feat_q <= bus_wdata;
          3'd2: secc_q <= bus_wdata;
          3'd3: secn_q <= bus_wdata;
          3'd4: cyll_q <= bus_wdata;
          3'd5: cylh_q <= bus_wdata;
          3'd6: dh_q   <= bus_wdata;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        cmd_q <= bus_wdata;
        bsy   <= 1'b1;
        drdy  <= 1'b0;
        errb  <= 1'b0;
        pend  <= 1'b0;
      end
      if (stat_rd) pend <= 1'b0;
      if (done_ok) begin
        bsy   <= 1'b0;
        drdy  <= 1'b1;
        errb  <= exec_err;
        err_q <= exec_err ? err_code : 8'h00;
        pend  <= 1'b1;
      end
      if (ctl_wr) nien <= bus_wdata[1];
      if (ctl_wr && bus_wdata[2]) begin
        srst <= 1'b1; bsy <= 1'b1; drdy <= 1'b0; errb <= 1'b0; pend <= 1'b0;
        feat_q <= '0; secc_q <= '0; secn_q <= '0; cyll_q <= '0;
        cylh_q <= '0; dh_q <= '0; err_q <= '0; hold_cnt <= '0;
      end else if (ctl_wr && srst) begin
        srst     <= 1'b0;
        hold_cnt <= HW'(RST_HOLD);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (hold_cnt == HW'(1)) begin
          bsy  <= 1'b0;
          drdy <= 1'b1;
        end
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start); // R6
  AST_UNSEL_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_sel && cb_wr && bus_addr == 3'd7) |=> !cmd_start); // R4
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (!bsy && drdy && pend)); // R7
  AST_STAT_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_ok && !cmd_wr) |=> !intrq); // R8
  AST_BUSY_HOLDS_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && cb_wr) |=> $stable(lba)); // R9
  AST_SRST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> bsy); // R10
  AST_SRST_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst) |-> bsy); // R10

endmodule

// File: tb/sim_ata_taskfile_regs.sv
`timescale 1ns/1ps
module sim_ata_taskfile_regs;
  localparam logic DEV = 1'b0;
  localparam int   HOLD = 3;

  logic clk = 0, rst_n = 0;
  logic bus_cs = 0, bus_ctl = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, err_code = 0;
  logic exec_done = 0, exec_err = 0, drq_i = 0;
  logic [7:0] bus_rdata, sector_count, features, cmd_code;
  logic [27:0] lba;
  logic dev_sel, lba_mode, cmd_start, soft_rst, intrq;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  ata_taskfile_regs #(.DEV_ID(DEV), .RST_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_ctl(bus_ctl),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exec_done(exec_done),
    .exec_err(exec_err), .err_code(err_code), .drq_i(drq_i),
    .dev_sel(dev_sel), .lba(lba), .lba_mode(lba_mode),
    .sector_count(sector_count), .features(features), .cmd_start(cmd_start),
    .cmd_code(cmd_code), .soft_rst(soft_rst), .intrq(intrq));

  always #10 clk = ~clk;

  // behavioural reference state
  byte unsigned m_tf[8];  // 1 feat,2 secc,3 secn,4 cyl lo,5 cyl hi,6 drive/head
  byte unsigned m_err, m_cmd;
  bit m_bsy, m_drdy, m_errb, m_pend, m_nien, m_srst, m_start;
  int m_hold;

  function automatic bit m_sel();
    return m_tf[6][4] == DEV;
  endfunction
  function automatic logic [7:0] m_status();
    return {m_bsy, m_drdy, 2'b00, drq_i && !m_bsy, 2'b00, m_errb};
  endfunction
  function automatic logic [7:0] m_rdata();
    if (!(bus_cs && bus_rd) || !m_sel()) return 8'h00;
    if (bus_ctl) return (bus_addr == 2) ? m_status() : 8'h00;
    if (bus_addr == 0) return 8'h00;
    if (bus_addr == 1) return m_err;
    if (bus_addr == 7) return m_status();
    return m_tf[bus_addr];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic m_reset();
    foreach (m_tf[i]) m_tf[i] = 0;
    m_err = 0; m_cmd = 0; m_bsy = 0; m_drdy = 1; m_errb = 0; m_pend = 0;
    m_nien = 0; m_srst = 0; m_start = 0; m_hold = 0;
  endtask

  task automatic m_clock();
    bit wa, ra, tfok, cmdw, statr, dok, sel;
    sel   = m_sel();
    wa    = bus_cs && bus_wr;
    ra    = bus_cs && bus_rd;
    tfok  = wa && !bus_ctl && !m_bsy;
    cmdw  = tfok && bus_addr == 7 && sel;
    statr = ra && !bus_ctl && bus_addr == 7 && sel;
    dok   = exec_done && m_bsy && !m_srst && m_hold == 0;
    m_start = cmdw;
    if (tfok && bus_addr >= 1 && bus_addr <= 6) m_tf[bus_addr] = bus_wdata;
    if (cmdw) begin m_cmd = bus_wdata; m_bsy = 1; m_drdy = 0; m_errb = 0; m_pend = 0; end
    if (statr) m_pend = 0;
    if (dok) begin
      m_bsy = 0; m_drdy = 1; m_errb = exec_err; m_pend = 1;
      m_err = exec_err ? err_code : 8'h00;
    end
    if (wa && bus_ctl && bus_addr == 2) begin
      m_nien = bus_wdata[1];
      if (bus_wdata[2]) begin
        m_srst = 1; m_bsy = 1; m_drdy = 0; m_errb = 0; m_pend = 0;
        foreach (m_tf[i]) m_tf[i] = 0;
        m_err = 0; m_hold = 0;
        return;
      end else if (m_srst) begin
        m_srst = 0; m_hold = HOLD;
        return;
      end
    end
    if (m_hold != 0) begin
      m_hold--;
      if (m_hold == 0) begin m_bsy = 0; m_drdy = 1; end
    end
  endtask

  task automatic step(string tag);
    #1;
    chk({tag, " rdata"}, bus_rdata, m_rdata());
    chk("R8 intrq", intrq, m_pend && !m_nien && m_sel());
    chk("R6 cmd_start", cmd_start, m_start);
    chk("R6 cmd_code", cmd_code, m_cmd);
    chk("R5 lba", lba, {m_tf[6][3:0], m_tf[5], m_tf[4], m_tf[3]});
    chk("R5 lba_mode", lba_mode, m_tf[6][6]);
    chk("R4 dev_sel", dev_sel, m_sel());
    chk("R2 sector_count", sector_count, m_tf[2]);
    chk("R3 features", features, m_tf[1]);
    chk("R10 soft_rst", soft_rst, m_srst);
    @(posedge clk);
    m_clock();
    @(negedge clk);
  endtask

  task automatic clear_bus();
    bus_cs = 0; bus_wr = 0; bus_rd = 0; bus_ctl = 0; bus_addr = 0; bus_wdata = 0;
    exec_done = 0; exec_err = 0;
  endtask

  task automatic wr(bit ctl, int a, byte unsigned d, string tag);
    bus_cs = 1; bus_wr = 1; bus_ctl = ctl; bus_addr = 3'(a); bus_wdata = d;
    step(tag);
    clear_bus();
  endtask

  task automatic rd(bit ctl, int a, logic [7:0] exp, string tag);
    bus_cs = 1; bus_rd = 1; bus_ctl = ctl; bus_addr = 3'(a);
    #1 chk(tag, bus_rdata, exp);
    step(tag);
    clear_bus();
  endtask

  task automatic done(bit e, byte unsigned code, string tag);
    exec_done = 1; exec_err = e; err_code = code;
    step(tag);
    clear_bus();
  endtask

  task automatic idle(string tag);
    step(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1");
    // R1 reset state
    rd(0, 7, 8'h40, "R1");
    rd(0, 2, 8'h00, "R1");
    rd(0, 6, 8'h00, "R1");
    chk("R1 intrq", intrq, 0);
    // R2 R5 task-file load and address assembly
    wr(0, 3, 8'h11, "R2");
    wr(0, 4, 8'h22, "R2");
    wr(0, 5, 8'h33, "R2");
    wr(0, 6, 8'h4A, "R2");
    wr(0, 2, 8'h08, "R2");
    chk("R5 lba", lba, 28'hA332211);
    chk("R5 lba_mode", lba_mode, 1);
    rd(0, 3, 8'h11, "R2");
    rd(0, 5, 8'h33, "R2");
    rd(0, 6, 8'h4A, "R2");
    wr(0, 0, 8'h99, "R2");
    rd(0, 0, 8'h00, "R2");
    // R3 shared offsets
    wr(0, 1, 8'h77, "R3");
    chk("R3 features", features, 8'h77);
    rd(0, 1, 8'h00, "R3");
    rd(1, 2, 8'h40, "R3");
    rd(1, 5, 8'h00, "R3");
    // R11 DRQ mirror
    drq_i = 1;
    rd(0, 7, 8'h48, "R11");
    // R6 command
    wr(0, 7, 8'h20, "R6");
    chk("R6 cmd_start", cmd_start, 1);
    chk("R6 cmd_code", cmd_code, 8'h20);
    rd(0, 7, 8'h80, "R11");
    drq_i = 0;
    // R9 busy blocks task file, control write passes
    wr(0, 3, 8'hEE, "R9");
    rd(0, 3, 8'h11, "R9");
    wr(0, 7, 8'h30, "R9");
    chk("R9 cmd_code", cmd_code, 8'h20);
    wr(1, 2, 8'h02, "R9");
    // R7 completion with nIEN set
    done(0, 8'h00, "R7");
    chk("R8 masked", intrq, 0);
    rd(1, 2, 8'h40, "R7");
    wr(1, 2, 8'h00, "R8");
    chk("R8 unmasked", intrq, 1);
    rd(1, 2, 8'h40, "R8");
    chk("R8 alt keeps", intrq, 1);
    rd(0, 7, 8'h40, "R8");
    chk("R8 status clears", intrq, 0);
    // R7 error completion
    wr(0, 7, 8'hC8, "R6");
    idle("R6");
    done(1, 8'h04, "R7");
    rd(0, 7, 8'h41, "R7");
    rd(0, 1, 8'h04, "R7");
    // R4 deselect hides pending interrupt and reads, blocks commands
    wr(0, 7, 8'h25, "R4");
    done(0, 8'h00, "R4");
    chk("R4 intrq sel", intrq, 1);
    wr(0, 6, 8'h10, "R4");
    chk("R4 dev_sel", dev_sel, 0);
    chk("R4 intrq unsel", intrq, 0);
    rd(0, 7, 8'h00, "R4");
    wr(0, 7, 8'h99, "R4");
    chk("R4 no start", cmd_start, 0);
    wr(0, 3, 8'h5C, "R4");
    wr(0, 6, 8'h05, "R4");
    chk("R4 reselect intrq", intrq, 1);
    rd(0, 3, 8'h5C, "R4");
    // R10 soft reset
    wr(1, 2, 8'h04, "R10");
    chk("R10 soft_rst", soft_rst, 1);
    chk("R10 intrq", intrq, 0);
    rd(0, 7, 8'h80, "R10");
    rd(0, 3, 8'h00, "R10");
    wr(0, 3, 8'h66, "R10");
    idle("R10");
    wr(1, 2, 8'h00, "R10");
    chk("R10 released", soft_rst, 0);
    rd(1, 2, 8'h80, "R10");
    idle("R10");
    idle("R10");
    rd(0, 7, 8'h40, "R10");
    for (int i = 0; i < 4; i++) idle("R10");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule